// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory

This block is a read-only serial memory that sends a stored image one bit per clock to a loader that samples on the rising edge. An internal bit counter chooses the bit on the serial output. The output is presented as a data value plus a drive-enable, so a shared wire can be resolved outside the block. A chip-enable input gates counting and driving. A combined reset/output-enable input clears the counter and floats the output, and a parameter sets its active level. A chain-enable output passes control to the next device in a daisy chain once this device's last bit has been read.

Control is a two-state machine. `ST_STREAM` is the normal reading state: each enabled edge moves the counter forward by one. `ST_SPENT` means the last bit has been read, and the state register doubles as the exhausted flag. The transitions are: **reset** (from any state to `ST_STREAM` with counter 0, whenever reset is active at an edge), **last-bit** (from `ST_STREAM` to `ST_SPENT` on an enabled edge while the counter holds the highest address), and **stay** (`ST_SPENT` holds until reset; `ST_STREAM` holds otherwise). Because the exhausted flag is registered, the chain-enable drops right after the edge that consumes the last bit. The next device's bit 0 is then present for the following edge, so the stream has no gap and no overlap.

Cascaded devices share the clock, the reset/output-enable wire and the data wire. The first device's chip-enable comes from the loader, and each later device's chip-enable comes from the chain-enable of the device before it.

Top module: `serial_cfg_rom`

## Requirements
- R1: Parameter `RST_HIGH` sets the active level of `rst_oe`. With 1, a high level is reset; with 0, a low level is reset. The two settings behave identically once their levels are mapped.
- R2: While reset is active, `data_oe` is 0 and `chain_ce_n` is 1, and the counter returns to bit 0. The first bit driven after release is image bit 0, where image bit k is `INIT[k]`.
- R3: With reset inactive, `ce_n` low and the device not exhausted, `data_oe` is 1 and `data_o` is the image bit at the counter. Each rising edge moves the counter forward by exactly one bit.
- R4: While `ce_n` is high, `standby` is 1, `data_oe` is 0, and neither the counter nor the state changes. Reading resumes at the bit where it stopped.
- R5: The enabled edge that reads bit `DEPTH-1` sets the exhausted state. After that edge, `data_oe` stays 0, the counter no longer moves, and `chain_ce_n` equals `ce_n` while reset is inactive.
- R6: `chain_ce_n` is 1 whenever reset is active, `ce_n` is high, or the device is not exhausted. Only reset clears the exhausted state.
- R7: When two devices are chained, the combined stream is the first image followed directly by the second, bit for bit, with no gap and no overlap. At no time are both `data_oe` outputs 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; rising edges advance the counter |
| rst_oe | input | 1 | Reset / output enable, active level set by `RST_HIGH` |
| ce_n | input | 1 | Chip enable, active low |
| data_o | output | 1 | Serial data value |
| data_oe | output | 1 | Drive enable for `data_o` (0 means high impedance) |
| chain_ce_n | output | 1 | Chip enable for the next device, active low |
| standby | output | 1 | High while the device is deselected |

## Verification
The assertions assume that `rst_oe` and `ce_n` are synchronous to `clk` and stable around its rising edge. They also assume reset is active at the first edge, so the state register starts defined. The bench changes both inputs shortly after each rising edge and compares the outputs at the falling edge. It starts every run with reset active on the first edge. The chained devices share one reset wire, so no device can be exhausted while its neighbour is being reset.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

    typedef enum logic {
        ST_STREAM = 1'b0,
        ST_SPENT  = 1'b1
    } rd_state_e;

endpackage

// File: rtl/serial_cfg_seq.sv
module serial_cfg_seq
    import serial_cfg_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_act,
    input  logic              ce_act,
    output logic [ADDR_W-1:0] addr_q,
    output rd_state_e         state_q
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    rd_state_e         state_d;
    logic [ADDR_W-1:0] addr_d;
    logic              at_last;

    assign at_last = (addr_q == LAST_ADDR);

    // next-state and counter decision
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        if (rst_act) begin
            state_d = ST_STREAM;
            addr_d  = '0;
        end else begin
            unique case (state_q)
                ST_STREAM: begin
                    if (ce_act) begin
                        if (at_last) begin
                            state_d = ST_SPENT;
                        end else begin
                            addr_d = addr_q + ADDR_W'(1);
                        end
                    end
                end
                ST_SPENT: begin
                    state_d = ST_SPENT;
                end
                default: begin
                    state_d = ST_STREAM;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        state_q <= state_d;
        addr_q  <= addr_d;
    end

endmodule

// File: rtl/serial_cfg_store.sv
module serial_cfg_store #(
    parameter int               DEPTH  = 64,
    parameter int               ADDR_W = $clog2(DEPTH),
    parameter logic [DEPTH-1:0] INIT   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              bit_o
);

    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr == ADDR_W'(i)) begin
                bit_o = INIT[i];
            end
        end
    end

endmodule

// File: rtl/serial_cfg_drive.sv
module serial_cfg_drive
    import serial_cfg_pkg::*;
(
    input  logic      rst_act,
    input  logic      ce_act,
    input  rd_state_e state_q,
    input  logic      bit_i,
    output logic      data_o,
    output logic      data_oe,
    output logic      chain_ce_n,
    output logic      standby
);

    // output process
    always_comb begin
        data_oe    = 1'b0;
        chain_ce_n = 1'b1;
        unique case (state_q)
            ST_STREAM: data_oe    = ce_act & ~rst_act;
            ST_SPENT:  chain_ce_n = ~(ce_act & ~rst_act);
            default: begin
                data_oe    = 1'b0;
                chain_ce_n = 1'b1;
            end
        endcase
        data_o  = bit_i & data_oe;
        standby = ~ce_act;
    end

endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom
    import serial_cfg_pkg::*;
#(
    parameter int               DEPTH    = 64,
    parameter bit               RST_HIGH = 1'b1,
    parameter logic [DEPTH-1:0] INIT     = '0
) (
    input  logic clk,
    input  logic rst_oe,
    input  logic ce_n,
    output logic data_o,
    output logic data_oe,
    output logic chain_ce_n,
    output logic standby
);

    localparam int ADDR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;

    logic              rst_act;
    logic              ce_act;
    logic [ADDR_W-1:0] addr_q;
    rd_state_e         state_q;
    logic              cur_bit;

    generate
        if (RST_HIGH) begin : g_rst_hi
            assign rst_act = rst_oe;
        end else begin : g_rst_lo
            assign rst_act = ~rst_oe;
        end
    endgenerate

    assign ce_act = ~ce_n;

    serial_cfg_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst_act (rst_act),
        .ce_act  (ce_act),
        .addr_q  (addr_q),
        .state_q (state_q)
    );

    serial_cfg_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .INIT(INIT)) u_store (
        .addr  (addr_q),
        .bit_o (cur_bit)
    );

    serial_cfg_drive u_drive (
        .rst_act    (rst_act),
        .ce_act     (ce_act),
        .state_q    (state_q),
        .bit_i      (cur_bit),
        .data_o     (data_o),
        .data_oe    (data_oe),
        .chain_ce_n (chain_ce_n),
        .standby    (standby)
    );

endmodule

// File: rtl/serial_cfg_rom_chk.sv
module serial_cfg_rom_chk
    import serial_cfg_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_act,
    input logic              ce_act,
    input logic [ADDR_W-1:0] addr_q,
    input rd_state_e         state_q,
    input logic              data_oe,
    input logic              chain_ce_n,
    input logic              standby
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    // R2: reset floats the output and keeps the chain enable high
    always @(posedge clk) begin
        if (rst_act) begin
            p_reset_float_r2: assert (!data_oe && chain_ce_n)
                else $error("R2 violated: output driven during reset");
        end
    end

    // R3: one step per enabled edge
    p_step_r3: assert property (@(posedge clk) disable iff (rst_act)
        (ce_act && state_q == ST_STREAM && addr_q != LAST_ADDR)
        |=> (addr_q == $past(addr_q) + ADDR_W'(1)))
        else $error("R3 violated: counter did not step by one");

    // R4: deselected means frozen
    p_freeze_r4: assert property (@(posedge clk) disable iff (rst_act)
        !ce_act |=> ($stable(addr_q) && $stable(state_q)))
        else $error("R4 violated: counter moved while deselected");

    // R4, R6: deselected means floated, standby, chain high
    p_standby_r4: assert property (@(posedge clk) disable iff (rst_act)
        !ce_act |-> (standby && !data_oe && chain_ce_n))
        else $error("R4 violated: standby outputs wrong");

    // R5: last bit read leads to exhausted state
    p_last_r5: assert property (@(posedge clk) disable iff (rst_act)
        (ce_act && state_q == ST_STREAM && addr_q == LAST_ADDR)
        |=> (state_q == ST_SPENT))
        else $error("R5 violated: exhausted state not entered");

    // R6: exhausted state is sticky and the counter stays put
    p_spent_sticky_r6: assert property (@(posedge clk) disable iff (rst_act)
        (state_q == ST_SPENT) |=> (state_q == ST_SPENT && $stable(addr_q)))
        else $error("R6 violated: exhausted state left without reset");

    // R7: hand-off never overlaps with own drive
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst_act)
        !chain_ce_n |-> !data_oe)
        else $error("R7 violated: chain enabled while driving");

endmodule

bind serial_cfg_rom serial_cfg_rom_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_act    (rst_act),
    .ce_act     (ce_act),
    .addr_q     (addr_q),
    .state_q    (state_q),
    .data_oe    (data_oe),
    .chain_ce_n (chain_ce_n),
    .standby    (standby)
);

// File: tb/serial_cfg_rom_bench.sv
module serial_cfg_rom_bench;

    localparam int D = 16;
    localparam logic [D-1:0] IMG_A = 16'hA5C3;
    localparam logic [D-1:0] IMG_B = 16'h3E71;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_pin = 1'b1;
    logic ce_n    = 1'b1;
    logic rst_pin_n;
    assign rst_pin_n = ~rst_pin;

    logic d_a, oe_a, ch_a, sb_a;
    logic d_b, oe_b, ch_b, sb_b;
    logic d_l, oe_l, ch_l, sb_l;

    serial_cfg_rom #(.DEPTH(D), .RST_HIGH(1'b1), .INIT(IMG_A)) u_serial_cfg_rom (
        .clk(clk), .rst_oe(rst_pin), .ce_n(ce_n),
        .data_o(d_a), .data_oe(oe_a), .chain_ce_n(ch_a), .standby(sb_a)
    );

    serial_cfg_rom #(.DEPTH(D), .RST_HIGH(1'b1), .INIT(IMG_B)) u_serial_cfg_rom_b (
        .clk(clk), .rst_oe(rst_pin), .ce_n(ch_a),
        .data_o(d_b), .data_oe(oe_b), .chain_ce_n(ch_b), .standby(sb_b)
    );

    serial_cfg_rom #(.DEPTH(D), .RST_HIGH(1'b0), .INIT(IMG_A)) u_serial_cfg_rom_lo (
        .clk(clk), .rst_oe(rst_pin_n), .ce_n(ce_n),
        .data_o(d_l), .data_oe(oe_l), .chain_ce_n(ch_l), .standby(sb_l)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  en     = 1'b0;
    bit  done   = 1'b0;
    int  pa = 0, pb = 0;
    bit  sa = 1'b0, sb = 1'b0;
    bit  stream_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: bit positions and exhausted flags
    bit m_ce0, m_ce1;
    always @(posedge clk) begin
        m_ce0 = !ce_n;
        m_ce1 = !rst_pin && m_ce0 && sa;
        if (rst_pin) begin
            pa = 0; pb = 0; sa = 1'b0; sb = 1'b0;
        end else begin
            if (m_ce0 && !sa) begin
                if (pa == D - 1) sa = 1'b1; else pa++;
            end
            if (m_ce1 && !sb) begin
                if (pb == D - 1) sb = 1'b1; else pb++;
            end
        end
    end

    // per-cycle comparison at the falling edge
    bit    e_oe_a, e_oe_b, e_ch_a, e_ch_b;
    string tag_a;
    always @(negedge clk) begin
        if (en) begin
            e_ch_a = !(!rst_pin && !ce_n && sa);
            e_oe_a = !rst_pin && !ce_n && !sa;
            e_oe_b = !rst_pin && !e_ch_a && !sb;
            e_ch_b = !(!rst_pin && !e_ch_a && sb);
            tag_a  = rst_pin ? "R2" : (ce_n ? "R4" : "R3");
            chk(oe_a == e_oe_a, {tag_a, " data_oe first"}, oe_a, e_oe_a);
            if (e_oe_a) chk(d_a == IMG_A[pa], {tag_a, " data first"}, d_a, IMG_A[pa]);
            chk(ch_a == e_ch_a, "R5 R6 chain first", ch_a, e_ch_a);
            chk(sb_a == ce_n, "R4 standby", sb_a, ce_n);
            chk(oe_b == e_oe_b, "R5 data_oe second", oe_b, e_oe_b);
            if (e_oe_b) chk(d_b == IMG_B[pb], "R7 data second", d_b, IMG_B[pb]);
            chk(ch_b == e_ch_b, "R6 chain second", ch_b, e_ch_b);
            chk(!(oe_a && oe_b), "R7 single driver", oe_a + oe_b, 1);
            chk(oe_l == oe_a && ch_l == ch_a && sb_l == sb_a && (!oe_a || d_l == d_a),
                "R1 low polarity", {oe_l, ch_l, d_l}, {oe_a, ch_a, d_a});
            if (oe_a ^ oe_b) stream_q.push_back(oe_a ? d_a : d_b);
        end
    end

    task automatic step(input int n, input logic r, input logic c);
        repeat (n) begin
            @(posedge clk);
            #2;
            rst_pin = r;
            ce_n    = c;
        end
    endtask

    task automatic check_stream();
        chk(stream_q.size() == 2 * D, "R7 stream length", stream_q.size(), 2 * D);
        for (int i = 0; i < stream_q.size() && i < 2 * D; i++) begin
            if (i < D) chk(stream_q[i] == IMG_A[i], "R7 stream bit", stream_q[i], IMG_A[i]);
            else       chk(stream_q[i] == IMG_B[i - D], "R7 stream bit", stream_q[i], IMG_B[i - D]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        @(posedge clk);
        #2;
        en = 1'b1;
        step(3, 1'b1, 1'b0);      // R2: reset with chip enabled
        stream_q.delete();
        step(5, 1'b0, 1'b0);      // R3: read five bits
        step(3, 1'b0, 1'b1);      // R4: deselect, counter frozen
        step(45, 1'b0, 1'b0);     // R5, R7: through both images
        check_stream();
        step(3, 1'b0, 1'b1);      // R6: chain follows chip enable
        step(2, 1'b0, 1'b0);
        step(2, 1'b1, 1'b0);      // R2, R6: reset clears exhausted
        stream_q.delete();
        step(10, 1'b0, 1'b0);
        step(2, 1'b1, 1'b0);      // R2: restart mid-stream
        stream_q.delete();
        step(40, 1'b0, 1'b0);
        check_stream();           // R7 after restart
        step(2, 1'b1, 1'b1);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            finish_run();
        end
    end

endmodule